// File: doc/BRIEF.md
# PHY Mode and Tuning Bring-up Sequencer

This block brings a dual-purpose serial PHY, which can run as a PCIe or a USB 3.0 lane, into USB 3.0 operation after power-up. A single-cycle request carries the PHY type wanted. Only the USB3 code is accepted. Any other code is refused at once with an error pulse, and nothing else happens.

An accepted request starts a fixed sequence. First the PHY reset is driven for a parameterised hold time. Then the two-bit mode field of a memory-mapped control word is rewritten in one cycle. Finally, five internal PHY registers get a masked read-modify-write each. These accesses go through an external handshake master: the sequencer raises a command and waits for a completion, which may carry a timeout flag.

The block reports the outcome with a one-cycle success pulse. A timeout on any access ends the sequence early with a one-cycle error pulse instead.

Top module: `phy_bringup_seq`

## Requirements
- R1: While rst_ni is low and right after it rises, busy_o, done_o, err_o, phy_rst_o, mode_we_o and cr_req_o are all 0.
- R2: A request taken while idle whose type differs from the USB3 code (2'b10 by default) produces an err_o pulse of one cycle in the next cycle. It causes no reset, no mode write and no command.
- R3: A request with the USB3 code raises phy_rst_o from the next cycle for exactly RST_HOLD_CYC cycles (default 500, i.e. 10 us at 50 MHz). No mode write and no command occurs while it is high.
- R4: In the first cycle after phy_rst_o falls, mode_we_o pulses for exactly one cycle. mode_wdata_o equals mode_rdata_i with bits [6:5] forced to 2'b11 and every other bit kept.
- R5: After the mode write, exactly ten commands follow, as read/write pairs to the same address. The address order is 0x102D, 0x1010, 0x1006, 0x1002, 0x0030 (cr_we_o is 0 for a read and 1 for a write).
- R6: The write to 0x102D carries rd | 0x0080, and the write to 0x1010 carries (rd & ~0x0FF0) | 0x0010. Here rd is the data returned by the preceding read.
- R7: The write to 0x1006 keeps only bit 6 of rd and sets bits 7, 9, 8 and 11: (rd & 0x0040) | 0x0B80.
- R8: The write to 0x1002 carries (rd & 0xC000) | 0x4B7F. This puts 0x16 in field [13:7] and 0x7F in field [6:0], and sets bit 14. The write to 0x0030 carries (rd & ~0x00F0) | 0x0080.
- R9: cr_req_o stays high until cr_done_i is seen. Until then cr_addr_o, cr_we_o and cr_wdata_o do not change. A completion is consumed in the cycle it is seen.
- R10: A completion with cr_err_i high makes err_o pulse in the next cycle and drops cr_req_o in that cycle. No further command and no done_o follow.
- R11: done_o pulses for one cycle, in the cycle after the completion of the final write, and never together with err_o.
- R12: A request that arrives while busy_o is high is ignored. The running sequence is neither restarted nor flagged with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bring-up request, one cycle |
| req_type_i | input | TYPE_W | PHY type requested |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Error pulse (bad type or access timeout) |
| phy_rst_o | output | 1 | PHY reset, active high |
| mode_rdata_i | input | MODE_W | Current value of the mode control word |
| mode_we_o | output | 1 | Mode control word write strobe |
| mode_wdata_o | output | MODE_W | New mode control word |
| cr_req_o | output | 1 | Command request to the handshake master |
| cr_we_o | output | 1 | Command direction, 1 = write |
| cr_addr_o | output | 16 | Internal PHY register address |
| cr_wdata_o | output | 16 | Write data |
| cr_done_i | input | 1 | Command completion, one cycle |
| cr_err_i | input | 1 | Completion carries a timeout |
| cr_rdata_i | input | 16 | Read data, valid with cr_done_i |

## Verification
The hardest situation to reach is a timeout at one exact access deep in the sequence, such as the fourth read or the final write. From the ports alone, this requires a master model that counts completed commands. The bench responder counts every command, answers each after a selectable latency, and flags a timeout on the access whose index is chosen for the run. Sweeping that index over all ten accesses covers every early-exit point. Sweeping read-data patterns and latencies shows that each merge keeps and overrides exactly the bits it should.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int unsigned CR_W   = 16;
  localparam int unsigned STEP_N = 5;
  localparam int unsigned IDX_W  = $clog2(STEP_N);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_MODE,
    ST_RD,
    ST_WR
  } seq_state_e;

  typedef struct packed {
    logic [CR_W-1:0] addr;
    logic [CR_W-1:0] keep;
    logic [CR_W-1:0] set;
  } step_t;

  // Execution order matters: later steps assume earlier ones are done.
  function automatic step_t step_at(logic [IDX_W-1:0] idx);
    step_t s;
    case (idx)
      IDX_W'(0): s = '{addr: 16'h102D, keep: 16'hFFFF, set: 16'h0080};
      IDX_W'(1): s = '{addr: 16'h1010, keep: 16'hF00F, set: 16'h0010};
      IDX_W'(2): s = '{addr: 16'h1006, keep: 16'h0040, set: 16'h0B80};
      IDX_W'(3): s = '{addr: 16'h1002, keep: 16'hC000, set: 16'h4B7F};
      IDX_W'(4): s = '{addr: 16'h0030, keep: 16'hFF0F, set: 16'h0080};
      default:   s = '{addr: 16'h0000, keep: 16'hFFFF, set: 16'h0000};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/phy_seq_rom.sv
module phy_seq_rom
  import phy_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [CR_W-1:0]  addr_o,
  output logic [CR_W-1:0]  keep_o,
  output logic [CR_W-1:0]  set_o,
  output logic             last_o
);
  step_t step;

  always_comb begin
    step   = step_at(idx_i);
    addr_o = step.addr;
    keep_o = step.keep;
    set_o  = step.set;
    last_o = (idx_i == IDX_W'(STEP_N - 1));
  end
endmodule

// File: rtl/phy_rmw_merge.sv
module phy_rmw_merge #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] rd_i,
  input  logic [W-1:0] keep_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] wr_o
);
  assign wr_o = (rd_i & keep_i) | set_i;
endmodule

// File: rtl/phy_hold_timer.sv
module phy_hold_timer #(
  parameter int unsigned CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CNT_W'(CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned TYPE_W       = 2,
  parameter int unsigned TYPE_USB3    = 2,
  parameter int unsigned MODE_W       = 32,
  parameter int unsigned MODE_LSB     = 5,
  parameter int unsigned MODE_FW      = 2,
  parameter int unsigned MODE_USB3    = 3,
  parameter int unsigned RST_HOLD_CYC = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [TYPE_W-1:0] req_type_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              phy_rst_o,
  input  logic [MODE_W-1:0] mode_rdata_i,
  output logic              mode_we_o,
  output logic [MODE_W-1:0] mode_wdata_o,
  output logic              cr_req_o,
  output logic              cr_we_o,
  output logic [CR_W-1:0]   cr_addr_o,
  output logic [CR_W-1:0]   cr_wdata_o,
  input  logic              cr_done_i,
  input  logic              cr_err_i,
  input  logic [CR_W-1:0]   cr_rdata_i
);
  localparam logic [MODE_W-1:0] MODE_FMASK =
    MODE_W'((1 << MODE_FW) - 1) << MODE_LSB;
  localparam logic [MODE_W-1:0] MODE_KEEP  = ~MODE_FMASK;
  localparam logic [MODE_W-1:0] MODE_SET   =
    (MODE_W'(MODE_USB3) << MODE_LSB) & MODE_FMASK;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CR_W-1:0]  wdata_q, wdata_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             tmr_load, tmr_exp;

  logic [CR_W-1:0]  step_keep, step_set, cr_merged;
  logic             step_last;

  phy_seq_rom u_rom (
    .idx_i  (idx_q),
    .addr_o (cr_addr_o),
    .keep_o (step_keep),
    .set_o  (step_set),
    .last_o (step_last)
  );

  phy_rmw_merge #(.W(CR_W)) u_cr_merge (
    .rd_i   (cr_rdata_i),
    .keep_i (step_keep),
    .set_i  (step_set),
    .wr_o   (cr_merged)
  );

  phy_rmw_merge #(.W(MODE_W)) u_mode_merge (
    .rd_i   (mode_rdata_i),
    .keep_i (MODE_KEEP),
    .set_i  (MODE_SET),
    .wr_o   (mode_wdata_o)
  );

  phy_hold_timer #(.CYC(RST_HOLD_CYC)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .expired_o (tmr_exp)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    wdata_d  = wdata_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (req_type_i == TYPE_W'(TYPE_USB3)) begin
            state_d  = ST_RST;
            tmr_load = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RST: begin
        if (tmr_exp) state_d = ST_MODE;
      end
      ST_MODE: begin
        idx_d   = '0;
        state_d = ST_RD;
      end
      ST_RD: begin
        if (cr_done_i) begin
          if (cr_err_i) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            wdata_d = cr_merged;
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (cr_done_i) begin
          if (cr_err_i) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (step_last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wdata_q <= wdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign phy_rst_o  = (state_q == ST_RST);
  assign mode_we_o  = (state_q == ST_MODE);
  assign cr_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign cr_we_o    = (state_q == ST_WR);
  assign cr_wdata_o = wdata_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int unsigned TYPE_W    = 2,
  parameter int unsigned TYPE_USB3 = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [TYPE_W-1:0] req_type_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              phy_rst_o,
  input logic              mode_we_o,
  input logic              cr_req_o,
  input logic              cr_we_o,
  input logic [15:0]       cr_addr_o,
  input logic [15:0]       cr_wdata_o,
  input logic              cr_done_i,
  input logic              cr_err_i
);
  // R2
  bad_type_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && req_type_i != TYPE_W'(TYPE_USB3)) |=> (err_o && !busy_o));

  // R3
  no_access_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rst_o |-> (!mode_we_o && !cr_req_o));

  // R4
  mode_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_rst_o) |-> mode_we_o);

  // R4
  mode_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_o |=> (!mode_we_o && cr_req_o && !cr_we_o));

  // R9
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_req_o && !cr_done_i) |=>
      (cr_req_o && $stable(cr_addr_o) && $stable(cr_we_o) && $stable(cr_wdata_o)));

  // R10
  timeout_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_req_o && cr_done_i && cr_err_i) |=> (err_o && !cr_req_o && !done_o));

  // R11
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cr_req_o && cr_we_o && cr_done_i && !cr_err_i));

  // R11
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R12
  busy_req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && !(cr_req_o && cr_done_i && cr_err_i)) |=> !err_o);
endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(
  .TYPE_W    (TYPE_W),
  .TYPE_USB3 (TYPE_USB3)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .req_type_i (req_type_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .phy_rst_o  (phy_rst_o),
  .mode_we_o  (mode_we_o),
  .cr_req_o   (cr_req_o),
  .cr_we_o    (cr_we_o),
  .cr_addr_o  (cr_addr_o),
  .cr_wdata_o (cr_wdata_o),
  .cr_done_i  (cr_done_i),
  .cr_err_i   (cr_err_i)
);

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb_top;
  localparam int unsigned HOLD = 7;
  localparam logic [1:0]  USB3 = 2'b10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  req_type_i = '0;
  logic        busy_o, done_o, err_o, phy_rst_o, mode_we_o;
  logic [31:0] mode_rdata_i = '0;
  logic [31:0] mode_wdata_o;
  logic        cr_req_o, cr_we_o;
  logic [15:0] cr_addr_o, cr_wdata_o;
  logic        cr_done_i = 1'b0, cr_err_i = 1'b0;
  logic [15:0] cr_rdata_i = '0;

  always #10 clk = ~clk;

  phy_bringup_seq #(.RST_HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_type_i(req_type_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .phy_rst_o(phy_rst_o),
    .mode_rdata_i(mode_rdata_i), .mode_we_o(mode_we_o), .mode_wdata_o(mode_wdata_o),
    .cr_req_o(cr_req_o), .cr_we_o(cr_we_o), .cr_addr_o(cr_addr_o),
    .cr_wdata_o(cr_wdata_o), .cr_done_i(cr_done_i), .cr_err_i(cr_err_i),
    .cr_rdata_i(cr_rdata_i)
  );

  int checks = 0, errors = 0;
  int lat = 1, fail_at = -1, acc_n = 0, wcnt = 0;
  logic [15:0] pat = '0;
  logic [15:0] log_addr [16];
  logic        log_we   [16];
  logic [15:0] log_data [16];
  int rst_cyc, overlap, mode_cnt, mode_late, done_cnt, err_cnt, both, req_after_err;
  logic [31:0] mode_seen;
  logic prev_rst = 1'b0;

  function automatic logic [15:0] rd_val(logic [15:0] a);
    return pat ^ a;
  endfunction

  function automatic logic [15:0] exp_addr(int k);
    case (k)
      0: return 16'h102D;
      1: return 16'h1010;
      2: return 16'h1006;
      3: return 16'h1002;
      default: return 16'h0030;
    endcase
  endfunction

  function automatic logic [15:0] exp_data(int k, logic [15:0] v);
    case (k)
      0: return v | 16'h0080;
      1: return (v & ~16'h0FF0) | 16'h0010;
      2: return (v & 16'h0040) | 16'h0080 | 16'h0300 | 16'h0800;
      3: return (v & ~16'h3FFF) | (16'h0016 << 7) | 16'h007F | 16'h4000;
      default: return (v & ~16'h00F0) | (16'h0008 << 4);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // handshake master model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_ni || cr_done_i) begin
        cr_done_i = 1'b0;
        cr_err_i  = 1'b0;
        wcnt      = 0;
      end else if (cr_req_o) begin
        wcnt++;
        if (wcnt >= lat) begin
          if (acc_n < 16) begin
            log_addr[acc_n] = cr_addr_o;
            log_we[acc_n]   = cr_we_o;
            log_data[acc_n] = cr_wdata_o;
          end
          cr_rdata_i = rd_val(cr_addr_o);
          cr_err_i   = (acc_n == fail_at);
          cr_done_i  = 1'b1;
          acc_n++;
        end
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (phy_rst_o) rst_cyc++;
      if (phy_rst_o && (cr_req_o || mode_we_o)) overlap++;
      if (mode_we_o) begin
        mode_cnt++;
        mode_seen = mode_wdata_o;
        if (!prev_rst) mode_late++;
      end
      if (done_o) done_cnt++;
      if (err_o) err_cnt++;
      if (done_o && err_o) both++;
      if (err_o && cr_req_o) req_after_err++;
      prev_rst = phy_rst_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic run(input logic [1:0] typ, input logic [15:0] p, input int l,
                     input int fa, input bit poke);
    int n;
    rst_cyc = 0; overlap = 0; mode_cnt = 0; mode_late = 0;
    done_cnt = 0; err_cnt = 0; both = 0; req_after_err = 0;
    pat = p; lat = l; fail_at = fa; acc_n = 0;
    mode_rdata_i = {p, ~p};
    @(negedge clk);
    req_i = 1'b1; req_type_i = typ;
    @(negedge clk);
    req_i = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      req_i = 1'b1; req_type_i = 2'b00;
      @(negedge clk);
      req_i = 1'b0;
      repeat (HOLD + 2) @(negedge clk);
      req_i = 1'b1; req_type_i = USB3;
      @(negedge clk);
      req_i = 1'b0;
    end
    n = 0;
    while (done_cnt == 0 && err_cnt == 0 && n < 500) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_good(input string tag);
    check(rst_cyc == HOLD, "R3 hold", rst_cyc, HOLD);
    check(overlap == 0, "R3 overlap", overlap, 0);
    check(mode_cnt == 1 && mode_late == 0, "R4 strobe", mode_cnt, 1);
    check(mode_seen == ((mode_rdata_i & ~32'h60) | 32'h60), "R4 data",
          mode_seen, (mode_rdata_i & ~32'h60) | 32'h60);
    check(acc_n == 10, "R5 count", acc_n, 10);
    for (int k = 0; k < 5; k++) begin
      check(log_addr[2*k] == exp_addr(k) && !log_we[2*k], "R5 read", log_addr[2*k], exp_addr(k));
      check(log_addr[2*k+1] == exp_addr(k) && log_we[2*k+1], "R5 write", log_addr[2*k+1], exp_addr(k));
      check(log_data[2*k+1] == exp_data(k, rd_val(exp_addr(k))),
            (k < 2) ? "R6 merge" : (k == 2) ? "R7 merge" : "R8 merge",
            log_data[2*k+1], exp_data(k, rd_val(exp_addr(k))));
    end
    check(done_cnt == 1 && err_cnt == 0 && both == 0, {"R11 ", tag}, done_cnt, 1);
  endtask

  initial begin
    logic [15:0] pats [6];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hAAAA;
    pats[3] = 16'h5555; pats[4] = 16'h1234; pats[5] = 16'hEDCB;

    repeat (3) @(negedge clk);
    // R1
    check(!busy_o && !done_o && !err_o && !phy_rst_o && !mode_we_o && !cr_req_o,
          "R1 in reset", {busy_o, done_o, err_o, phy_rst_o, mode_we_o, cr_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !err_o && !phy_rst_o && !mode_we_o && !cr_req_o,
          "R1 after reset", {busy_o, done_o, err_o, phy_rst_o, mode_we_o, cr_req_o}, 0);

    // R2: every non-USB3 code
    for (int t = 0; t < 4; t++) begin
      if (2'(t) == USB3) continue;
      run(2'(t), 16'h0F0F, 1, -1, 1'b0);
      check(err_cnt == 1 && done_cnt == 0, "R2 err", err_cnt, 1);
      check(rst_cyc == 0 && mode_cnt == 0 && acc_n == 0, "R2 no action",
            rst_cyc + mode_cnt + acc_n, 0);
    end

    // R5..R8, R11: data patterns x latencies
    for (int pi = 0; pi < 6; pi++)
      for (int l = 1; l <= 3; l++) begin
        run(USB3, pats[pi], l, -1, 1'b0);
        check_good("sweep");
      end

    // R10: timeout at each access
    for (int fa = 0; fa < 10; fa++) begin
      run(USB3, 16'h3C3C, 1 + (fa % 2), fa, 1'b0);
      check(err_cnt == 1 && done_cnt == 0, "R10 err", err_cnt, 1);
      check(acc_n == fa + 1, "R10 stop", acc_n, fa + 1);
      check(req_after_err == 0, "R10 req drop", req_after_err, 0);
    end

    // R12: requests while busy are ignored
    run(USB3, 16'h9669, 2, -1, 1'b1);
    check(err_cnt == 0, "R12 no err", err_cnt, 0);
    check_good("R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule